// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the processor-facing register front end of a dual-tone signalling transceiver. A host performs one-cycle accesses qualified by a strobe. A single select line and a read/write line turn each access into one of four operations: load the transmit code, fetch the received code, write a control nibble, or read status. Tone detection, tone synthesis and the filters are outside the block. They reach it only as a received-code strobe, a transmitter-ready strobe and a call-progress detector level.

Two 4-bit control registers share the control address. Writing control A with its route bit set sends exactly one following control write to control B, and that write also clears the route bit. Latched receive-ready and transmit-ready events are reported in status and drive an active-low interrupt level. Reading status clears them. When call-progress mode and interrupts are both on, the interrupt pin stops reporting events. It passes the inverted call-progress detector level straight through instead.

Top module: `tone_host_regs`

## Requirements
- R1: An access with `stb_i`=1, `sel_i`=0, `rw_i`=0 loads `wdata_i` into `tx_code_o` at the next clock edge and raises `tx_load_o` for exactly one cycle after that edge.
- R2: An access with `stb_i`=1, `sel_i`=0, `rw_i`=1 drives `rdata_o`, in the same cycle, with the most recently latched received code.
- R3: A control write (`stb_i`=1, `sel_i`=1, `rw_i`=0) goes to control A unless control A bit 3 is set. In that case it goes to control B and clears control A bit 3, so later writes go to control A again.
- R4: After reset, both control registers are 0, `irq_n_o` is 1, `tx_load_o` is 0 and a status read returns 0.
- R5: A `rx_valid_i` pulse in tone mode (control A bit 1 = 0) latches `rx_code_i` and sets the receive-ready flag, whether or not interrupts are enabled.
- R6: A `rx_valid_i` pulse in call-progress mode (control A bit 1 = 1) leaves the received code and the receive-ready flag unchanged.
- R7: A `tx_ready_i` pulse sets the transmit-ready flag only when burst mode (control B bit 0) is 1.
- R8: A status read (`stb_i`=1, `sel_i`=1, `rw_i`=1) returns bit 3 = 0, bit 2 = receive-ready, bit 1 = transmit-ready, bit 0 = pending. Pending is (control A bit 2) AND NOT (control A bit 1) AND (either flag).
- R9: Outside call-progress pass-through, `irq_n_o` is the inverse of pending. It goes low in the cycle after a flag is set while interrupts are enabled in tone mode, and it stays high while interrupts are disabled.
- R10: With control A bits 2 and 1 both set, `irq_n_o` equals NOT `cp_wave_i` in the same cycle, regardless of the flags.
- R11: A status read clears both flags at its clock edge. A set event in the same cycle wins over the clear.
- R12: With `stb_i`=0, no access takes effect: control registers, flags and `tx_code_o` are unchanged and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Access strobe, one cycle per access |
| sel_i | input | 1 | Register select: 0 data, 1 control/status |
| rw_i | input | 1 | 1 read, 0 write |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, valid during a read access |
| rx_valid_i | input | 1 | Received code held past guard time (pulse) |
| rx_code_i | input | 4 | Received code |
| tx_ready_i | input | 1 | Transmitter ready for more data (pulse) |
| cp_wave_i | input | 1 | Call-progress detector level |
| tx_code_o | output | 4 | Code for the tone generator |
| tx_load_o | output | 1 | One-cycle pulse after a transmit write |
| ctrl_a_o | output | 4 | Control A contents |
| ctrl_b_o | output | 4 | Control B contents |
| irq_n_o | output | 1 | Active-low interrupt / call-progress output |

## Verification
A status read that clears the flags can land in the same cycle as a new receive-ready or transmit-ready event. The bench provokes this by raising `rx_valid_i` during the status-read cycle. It judges the result twice. The read value taken before the edge must show the flag clear, and after the edge the flag and a low `irq_n_o` must remain. The same scenario also drives a read-without-strobe so that no clear takes effect.

// File: rtl/tone_host_pkg.sv
package tone_host_pkg;

  localparam int CTRL_W = 4;

  // control A fields
  localparam int A_TONE_EN = 0;
  localparam int A_CP_MODE = 1;
  localparam int A_IRQ_EN  = 2;
  localparam int A_ROUTE_B = 3;

  // control B fields
  localparam int B_BURST   = 0;
  localparam int B_TEST    = 1;
  localparam int B_SINGLE  = 2;
  localparam int B_COLROW  = 3;

  // status fields
  localparam int S_PEND    = 0;
  localparam int S_TXRDY   = 1;
  localparam int S_RXRDY   = 2;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TX_WR,
    ACC_RX_RD,
    ACC_CTRL_WR,
    ACC_STAT_RD
  } acc_e;

endpackage

// File: rtl/tone_access_decode.sv
module tone_access_decode
  import tone_host_pkg::*;
(
  input  logic stb_i,
  input  logic sel_i,
  input  logic rw_i,
  output acc_e acc_o
);

  always_comb begin
    acc_o = ACC_NONE;
    if (stb_i) begin
      unique case ({sel_i, rw_i})
        2'b00:   acc_o = ACC_TX_WR;
        2'b01:   acc_o = ACC_RX_RD;
        2'b10:   acc_o = ACC_CTRL_WR;
        default: acc_o = ACC_STAT_RD;
      endcase
    end
  end

endmodule

// File: rtl/tone_ctrl_regs.sv
module tone_ctrl_regs
  import tone_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_a_o,
  output logic [CTRL_W-1:0] ctrl_b_o
);

  logic [CTRL_W-1:0] a_q, a_d;
  logic [CTRL_W-1:0] b_q, b_d;
  logic              a_en, b_en;
  logic              to_b;

  assign to_b = a_q[A_ROUTE_B];

  always_comb begin
    a_en = 1'b0;
    b_en = 1'b0;
    a_d  = a_q;
    b_d  = b_q;
    if (ctrl_wr_i) begin
      if (to_b) begin
        b_en            = 1'b1;
        b_d             = wdata_i;
        a_en            = 1'b1;
        a_d[A_ROUTE_B]  = 1'b0;
      end else begin
        a_en = 1'b1;
        a_d  = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  assign ctrl_a_o = a_q;
  assign ctrl_b_o = b_q;

  // R3
  route_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && to_b) |=> (!a_q[A_ROUTE_B] && b_q == $past(wdata_i)));

endmodule

// File: rtl/tone_event_flags.sv
module tone_event_flags
  import tone_host_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_i,
  input  logic              stat_rd_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              rx_valid_i,
  input  logic [CODE_W-1:0] rx_code_i,
  input  logic              tx_ready_i,
  input  logic              cp_mode_i,
  input  logic              burst_i,
  output logic [CODE_W-1:0] tx_code_o,
  output logic              tx_load_o,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              rx_flag_o,
  output logic              tx_flag_o
);

  logic [CODE_W-1:0] tx_code_q, rx_code_q;
  logic              tx_load_q, rx_flag_q, tx_flag_q;
  logic              rx_flag_d, tx_flag_d;
  logic              rx_take, tx_take;

  assign rx_take = rx_valid_i && !cp_mode_i;
  assign tx_take = tx_ready_i && burst_i;

  always_comb begin
    rx_flag_d = rx_flag_q;
    tx_flag_d = tx_flag_q;
    if (stat_rd_i) begin
      rx_flag_d = 1'b0;
      tx_flag_d = 1'b0;
    end
    if (rx_take) rx_flag_d = 1'b1;
    if (tx_take) tx_flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_code_q <= '0;
      rx_code_q <= '0;
      tx_load_q <= 1'b0;
      rx_flag_q <= 1'b0;
      tx_flag_q <= 1'b0;
    end else begin
      tx_load_q <= tx_wr_i;
      rx_flag_q <= rx_flag_d;
      tx_flag_q <= tx_flag_d;
      if (tx_wr_i) tx_code_q <= wdata_i;
      if (rx_take) rx_code_q <= rx_code_i;
    end
  end

  assign tx_code_o = tx_code_q;
  assign tx_load_o = tx_load_q;
  assign rx_code_o = rx_code_q;
  assign rx_flag_o = rx_flag_q;
  assign tx_flag_o = tx_flag_q;

  // R1
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_i |=> (tx_load_q && tx_code_q == $past(wdata_i)));

  // R6
  cp_rx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && cp_mode_i && !stat_rd_i) |=> ($stable(rx_code_q) && $stable(rx_flag_q)));

  // R7
  tx_nonburst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_i && !burst_i && !stat_rd_i) |=> $stable(tx_flag_q));

  // R11
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !rx_take && !tx_take) |=> (!rx_flag_q && !tx_flag_q));

endmodule

// File: rtl/tone_irq_drive.sv
module tone_irq_drive (
  input  logic irq_en_i,
  input  logic cp_mode_i,
  input  logic cp_wave_i,
  input  logic rx_flag_i,
  input  logic tx_flag_i,
  output logic pending_o,
  output logic irq_n_o
);

  logic pass_cp;

  assign pass_cp   = irq_en_i && cp_mode_i;
  assign pending_o = irq_en_i && !cp_mode_i && (rx_flag_i || tx_flag_i);

  always_comb begin
    if (pass_cp) irq_n_o = !cp_wave_i;
    else         irq_n_o = !pending_o;
  end

endmodule

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import tone_host_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              sel_i,
  input  logic              rw_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic [CODE_W-1:0] rx_code_i,
  input  logic              tx_ready_i,
  input  logic              cp_wave_i,
  output logic [CODE_W-1:0] tx_code_o,
  output logic              tx_load_o,
  output logic [CTRL_W-1:0] ctrl_a_o,
  output logic [CTRL_W-1:0] ctrl_b_o,
  output logic              irq_n_o
);

  acc_e              acc;
  logic [CTRL_W-1:0] ctrl_a, ctrl_b;
  logic [CODE_W-1:0] rx_code;
  logic [CODE_W-1:0] status;
  logic              rx_flag, tx_flag, pending;

  tone_access_decode u_dec (
    .stb_i (stb_i),
    .sel_i (sel_i),
    .rw_i  (rw_i),
    .acc_o (acc)
  );

  tone_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr_i (acc == ACC_CTRL_WR),
    .wdata_i   (wdata_i[CTRL_W-1:0]),
    .ctrl_a_o  (ctrl_a),
    .ctrl_b_o  (ctrl_b)
  );

  tone_event_flags #(.CODE_W(CODE_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_wr_i    (acc == ACC_TX_WR),
    .stat_rd_i  (acc == ACC_STAT_RD),
    .wdata_i    (wdata_i),
    .rx_valid_i (rx_valid_i),
    .rx_code_i  (rx_code_i),
    .tx_ready_i (tx_ready_i),
    .cp_mode_i  (ctrl_a[A_CP_MODE]),
    .burst_i    (ctrl_b[B_BURST]),
    .tx_code_o  (tx_code_o),
    .tx_load_o  (tx_load_o),
    .rx_code_o  (rx_code),
    .rx_flag_o  (rx_flag),
    .tx_flag_o  (tx_flag)
  );

  tone_irq_drive u_irq (
    .irq_en_i  (ctrl_a[A_IRQ_EN]),
    .cp_mode_i (ctrl_a[A_CP_MODE]),
    .cp_wave_i (cp_wave_i),
    .rx_flag_i (rx_flag),
    .tx_flag_i (tx_flag),
    .pending_o (pending),
    .irq_n_o   (irq_n_o)
  );

  always_comb begin
    status          = '0;
    status[S_PEND]  = pending;
    status[S_TXRDY] = tx_flag;
    status[S_RXRDY] = rx_flag;
  end

  always_comb begin
    unique case (acc)
      ACC_RX_RD:   rdata_o = rx_code;
      ACC_STAT_RD: rdata_o = status;
      default:     rdata_o = '0;
    endcase
  end

  assign ctrl_a_o = ctrl_a;
  assign ctrl_b_o = ctrl_b;

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !ctrl_a[A_CP_MODE] && ctrl_a[A_IRQ_EN] && !stb_i) |=> !irq_n_o);

  // R12
  idle_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o)));

endmodule

// File: tb/tb_tone_host_regs.sv
`timescale 1ns/1ps
module tb_tone_host_regs;

  logic       clk, rst_n;
  logic       stb, sel, rw;
  logic [3:0] wdata, rdata;
  logic       rx_valid, tx_ready, cp_wave;
  logic [3:0] rx_code, tx_code, ctrl_a, ctrl_b;
  logic       tx_load, irq_n;

  int n_chk = 0;
  int n_bad = 0;

  tone_host_regs dut (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .sel_i(sel), .rw_i(rw),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid),
    .rx_code_i(rx_code), .tx_ready_i(tx_ready), .cp_wave_i(cp_wave),
    .tx_code_o(tx_code), .tx_load_o(tx_load), .ctrl_a_o(ctrl_a),
    .ctrl_b_o(ctrl_b), .irq_n_o(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    stb = 0; sel = 0; rw = 0; wdata = 0;
    rx_valid = 0; tx_ready = 0;
  endtask

  // one clock; inputs set by caller before, cleared after
  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic acc(input logic s, input logic r, input logic [3:0] d);
    stb = 1; sel = s; rw = r; wdata = d;
    tick();
  endtask

  task automatic stat_rd(input string req, input int exp);
    stb = 1; sel = 1; rw = 1; #1;
    chk(req, rdata, exp);
    tick();
  endtask

  task automatic t_reset();
    chk("R4 ctrl_a", ctrl_a, 0);
    chk("R4 ctrl_b", ctrl_b, 0);
    chk("R4 irq_n", irq_n, 1);
    chk("R4 tx_load", tx_load, 0);
    stat_rd("R4 status", 0);
  endtask

  task automatic t_tx_write();
    acc(0, 0, 4'h9);
    chk("R1 tx_code", tx_code, 9);
    chk("R1 tx_load high", tx_load, 1);
    tick();
    chk("R1 tx_load one cycle", tx_load, 0);
  endtask

  task automatic t_route();
    acc(1, 0, 4'h8);
    chk("R3 A written", ctrl_a, 8);
    acc(1, 0, 4'h5);
    chk("R3 B written", ctrl_b, 5);
    chk("R3 route cleared", ctrl_a, 0);
    acc(1, 0, 4'h3);
    chk("R3 back to A", ctrl_a, 3);
    chk("R3 B kept", ctrl_b, 5);
  endtask

  task automatic t_rx_irq();
    acc(1, 0, 4'h4);
    rx_valid = 1; rx_code = 4'h7; tick();
    chk("R9 irq low", irq_n, 0);
    stat_rd("R5 R8 status", 4'h5);
    chk("R11 irq released", irq_n, 1);
    stb = 1; sel = 0; rw = 1; #1;
    chk("R2 rx code", rdata, 7);
    tick();
    stat_rd("R11 cleared", 0);
  endtask

  task automatic t_rx_noirq();
    acc(1, 0, 4'h0);
    rx_valid = 1; rx_code = 4'hA; tick();
    chk("R9 irq disabled", irq_n, 1);
    stat_rd("R5 R8 no pending", 4'h4);
  endtask

  task automatic t_tx_ready();
    acc(1, 0, 4'h4);
    tx_ready = 1; tick();
    chk("R9 tx irq", irq_n, 0);
    stat_rd("R7 R8 tx status", 4'h3);
    acc(1, 0, 4'hC);
    acc(1, 0, 4'h0);
    chk("R3 A after B", ctrl_a, 4);
    chk("R7 burst off", ctrl_b, 0);
    tx_ready = 1; tick();
    chk("R7 no tx irq", irq_n, 1);
    stat_rd("R7 no flag", 0);
  endtask

  task automatic t_cp();
    acc(1, 0, 4'h6);
    rx_valid = 1; rx_code = 4'h1; tick();
    cp_wave = 0; #1;
    chk("R10 wave low", irq_n, 1);
    stat_rd("R6 no rx flag", 0);
    stb = 1; sel = 0; rw = 1; #1;
    chk("R6 code kept", rdata, 4'hA);
    tick();
    cp_wave = 1; #1;
    chk("R10 wave high", irq_n, 0);
    cp_wave = 0; #1;
    chk("R10 wave follows", irq_n, 1);
  endtask

  task automatic t_same_cycle();
    acc(1, 0, 4'h4);
    stb = 1; sel = 1; rw = 1; rx_valid = 1; rx_code = 4'h3; #1;
    chk("R11 read before set", rdata, 0);
    tick();
    chk("R11 set wins irq", irq_n, 0);
    stb = 0; sel = 1; rw = 1; wdata = 4'hF; #1;
    chk("R12 no read data", rdata, 0);
    tick();
    chk("R12 flag survives", irq_n, 0);
    stb = 0; sel = 1; rw = 0; wdata = 4'hF; tick();
    chk("R12 ctrl unchanged", ctrl_a, 4);
    stb = 0; sel = 0; rw = 0; wdata = 4'hE; tick();
    chk("R12 tx unchanged", tx_code, 9);
    stat_rd("R11 set wins status", 4'h5);
  endtask

  initial begin
    idle();
    rx_code = 0; cp_wave = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_tx_write();
    t_route();
    t_rx_irq();
    t_rx_noirq();
    t_tx_ready();
    t_cp();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule